// File: doc/BRIEF.md
# UTOPIA Level 2 Receive Cell Port

This block is the last stage of a receive path. An upstream cell processor, clocked by the line clock, hands over ATM cells that have already been checked and filtered. It delivers them one byte at a time with a start-of-cell strobe. The block stores whole cells in a small multi-cell buffer. It then serves them to an ATM-layer device clocked by its own unrelated clock, over a UTOPIA Level 2 style receive port. On that port the device polls with an address, selects the port, and pulls the cell out with an active-low enable.

On the write side, a three-state machine runs the buffer. In `W_IDLE` it waits for a start byte. `W_IDLE -> W_FILL` is taken on a start byte when a slot is free. `W_IDLE -> W_DROP` is taken on a start byte when the buffer is full. `W_FILL -> W_IDLE` is taken on the 53rd byte, which commits the cell. `W_FILL -> W_FILL` on a start byte restarts the same slot. `W_DROP -> W_IDLE` is taken on the 53rd byte of the dropped cell, and `W_DROP -> W_FILL` on a new start byte when space has appeared. The count of committed cells crosses to the read side in Gray code, and the count of freed cells crosses back the same way.

On the read side, a two-state machine serves the ATM-layer device. In `R_IDLE` it waits for a cell to be requested. `R_IDLE -> R_XFER` is taken on the first transfer of a cell. `R_XFER -> R_IDLE` is taken on the last transfer, which frees the slot. The bus runs 8 or 16 bits wide, chosen by a configuration input, and the port answers only at its configured 5-bit address.

Top module: `utopia_rx_port`

## Requirements
- R1: A cell becomes visible on the read side only after all 53 of its bytes have been written; with 52 bytes written, `rx_clav` stays low.
- R2: `rx_clav` is high one `rx_clk` cycle after `rx_addr` equals `cfg_port_addr` while at least one committed cell is not yet fully read. It is low otherwise, including whenever the polled address differs.
- R3: Data flows only after the port was selected: `rx_enb_n` high with `rx_addr == cfg_port_addr` selects it, and `rx_enb_n` high with any other address deselects it. When the port is not selected, or in a cycle that follows `rx_enb_n` high, `rx_data` and `rx_soc` are zero and no cell is consumed.
- R4: With `cfg_wide = 0`, a cell takes 53 transfers. Byte j of the cell appears on `rx_data[7:0]` in order, and `rx_data[15:8]` is zero.
- R5: With `cfg_wide = 1`, a cell takes 27 transfers. Transfer k carries byte 2k on `rx_data[15:8]` and byte 2k+1 on `rx_data[7:0]`, and the low byte of the last transfer is a zero pad.
- R6: `rx_soc` is high on exactly the first transfer of each cell.
- R7: `rx_prty` is odd parity over the active data bits: bits 7:0 in 8-bit mode, bits 15:0 in 16-bit mode.
- R8: Cells are delivered in the order their writes completed.
- R9: A start byte that arrives while all slots are occupied drops that whole cell. `ovf_flag` then rises and stays high until the write-side reset.
- R10: A start byte arriving in the middle of a cell abandons the partial cell and begins a new one in the same slot.
- R11: Raising `rx_enb_n` in the middle of a cell pauses it. When the enable returns, the cell resumes with the next byte or word, and `rx_soc` stays low.
- R12: After reset, `rx_clav`, `rx_soc`, `rx_data` and `ovf_flag` are zero and `rx_prty` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Line-side clock |
| wr_rst_n | input | 1 | Line-side active-low reset |
| wr_valid | input | 1 | A cell byte is present |
| wr_soc | input | 1 | The present byte is the first of a cell |
| wr_byte | input | 8 | Cell byte |
| ovf_flag | output | 1 | Sticky: a cell was dropped because the buffer was full |
| rx_clk | input | 1 | ATM-layer clock |
| rx_rst_n | input | 1 | ATM-layer active-low reset |
| cfg_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cfg_port_addr | input | 5 | Address this port answers to |
| rx_enb_n | input | 1 | Active-low read enable |
| rx_addr | input | 5 | Polled or selected port address |
| rx_data | output | 16 | Cell data |
| rx_soc | output | 1 | First transfer of a cell |
| rx_prty | output | 1 | Odd parity over the active data bits |
| rx_clav | output | 1 | A complete cell is available |

## Verification
The properties assume that `cfg_wide` and `cfg_port_addr` are held constant while either reset is released. They also assume that `wr_byte`, `wr_valid` and `wr_soc` are steady around each `wr_clk` edge. The stimulus sets the configuration only while the port is idle with no cell in flight, and drives every input at the falling edge of its own clock. Mode changes happen only after all buffered cells have been drained, so no cell is ever read under a bus width other than the one that was in force when it was requested.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
    localparam int CELL_BYTES = 53;
    localparam int CELL_WORDS = 27;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FILL,
        W_DROP
    } wr_state_e;

    typedef enum logic {
        R_IDLE,
        R_XFER
    } rd_state_e;
endpackage

// File: rtl/utopia_rx_sync.sv
module utopia_rx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/utopia_rx_store.sv
module utopia_rx_store #(
    parameter int DEPTH = 108,
    parameter int AW    = 7
) (
    input  logic          wr_clk,
    input  logic [1:0]    we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    // lane 1 holds even bytes (upper half), lane 0 holds odd bytes
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        always_ff @(posedge wr_clk) begin
            if (we[g]) begin
                mem[waddr] <= wdata[g*8 +: 8];
            end
        end

        assign rdata[g*8 +: 8] = mem[raddr];
    end
endmodule

// File: rtl/utopia_rx_wr.sv
module utopia_rx_wr
    import utopia_rx_pkg::*;
#(
    parameter int CELLS = 4,
    parameter int PW    = $clog2(CELLS) + 1,
    parameter int AW    = $clog2(CELLS * CELL_WORDS)
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_valid,
    input  logic          wr_soc,
    input  logic [7:0]    wr_byte,
    input  logic [PW-1:0] rd_gray_sync,
    output logic [PW-1:0] wr_gray,
    output logic [1:0]    mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          ovf_flag
);
    localparam int SW = PW - 1;
    localparam logic [5:0] LAST_BYTE = 6'(CELL_BYTES - 1);

    wr_state_e     state, nstate;
    logic [5:0]    cnt;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] rd_bin;
    logic          full;
    logic          start;
    logic          last;
    logic          accept;
    logic          commit;
    logic [5:0]    byte_idx;
    logic [SW-1:0] slot;

    always_comb begin
        rd_bin[PW-1] = rd_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rd_bin[i] = rd_bin[i+1] ^ rd_gray_sync[i];
        end
    end

    assign full  = ((wr_bin - rd_bin) == PW'(CELLS));
    assign start = wr_valid && wr_soc;
    assign last  = (cnt == LAST_BYTE);
    assign slot  = wr_bin[SW-1:0];

    // state register
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) state <= W_IDLE;
        else           state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            W_IDLE: if (start) nstate = full ? W_DROP : W_FILL;
            W_FILL: if (wr_valid && !wr_soc && last) nstate = W_IDLE;
            W_DROP: begin
                if (start)                nstate = full ? W_DROP : W_FILL;
                else if (wr_valid && last) nstate = W_IDLE;
            end
        endcase
    end

    // outputs towards the store
    always_comb begin
        accept    = wr_valid && ((state == W_FILL) || (wr_soc && !full));
        commit    = wr_valid && (state == W_FILL) && !wr_soc && last;
        byte_idx  = wr_soc ? 6'd0 : cnt;
        mem_addr  = AW'(slot) * AW'(CELL_WORDS) + AW'(byte_idx[5:1]);
        mem_we[1] = accept && !byte_idx[0];
        mem_we[0] = (accept && byte_idx[0]) || commit;
        mem_wdata = {wr_byte, commit ? 8'h00 : wr_byte};
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            cnt      <= '0;
            wr_bin   <= '0;
            wr_gray  <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_valid) begin
                if (wr_soc)                 cnt <= 6'd1;
                else if (state != W_IDLE)   cnt <= last ? 6'd0 : cnt + 6'd1;
            end
            if (start && (state != W_FILL) && full) ovf_flag <= 1'b1;
            if (commit) begin
                wr_bin  <= wr_bin + 1'b1;
                wr_gray <= (wr_bin + 1'b1) ^ ((wr_bin + 1'b1) >> 1);
            end
        end
    end
endmodule

// File: rtl/utopia_rx_rd.sv
module utopia_rx_rd
    import utopia_rx_pkg::*;
#(
    parameter int CELLS = 4,
    parameter int PW    = $clog2(CELLS) + 1,
    parameter int AW    = $clog2(CELLS * CELL_WORDS)
) (
    input  logic          rx_clk,
    input  logic          rx_rst_n,
    input  logic          cfg_wide,
    input  logic [4:0]    cfg_port_addr,
    input  logic          rx_enb_n,
    input  logic [4:0]    rx_addr,
    input  logic [PW-1:0] wr_gray_sync,
    output logic [PW-1:0] rd_gray,
    output logic [AW-1:0] mem_raddr,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   rx_data,
    output logic          rx_soc,
    output logic          rx_prty,
    output logic          rx_clav
);
    localparam int SW = PW - 1;

    rd_state_e     state, nstate;
    logic [5:0]    idx;
    logic [5:0]    cur;
    logic [5:0]    last_idx;
    logic [5:0]    off;
    logic [PW-1:0] rd_bin;
    logic [PW-1:0] wr_bin;
    logic          avail;
    logic          sel;
    logic          go;
    logic          at_last;
    logic          addr_hit;
    logic [15:0]   word;

    always_comb begin
        wr_bin[PW-1] = wr_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wr_bin[i] = wr_bin[i+1] ^ wr_gray_sync[i];
        end
    end

    assign avail    = (wr_bin != rd_bin);
    assign addr_hit = (rx_addr == cfg_port_addr);
    assign cur      = (state == R_IDLE) ? 6'd0 : idx;
    assign last_idx = cfg_wide ? 6'(CELL_WORDS - 1) : 6'(CELL_BYTES - 1);
    assign at_last  = (cur == last_idx);
    assign go       = sel && !rx_enb_n && ((state == R_XFER) || avail);
    assign off      = cfg_wide ? cur : {1'b0, cur[5:1]};
    assign mem_raddr = AW'(rd_bin[SW-1:0]) * AW'(CELL_WORDS) + AW'(off);
    assign word     = cfg_wide ? mem_rdata
                               : {8'h00, cur[0] ? mem_rdata[7:0] : mem_rdata[15:8]};

    // state register
    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) state <= R_IDLE;
        else           state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            R_IDLE: if (go) nstate = R_XFER;
            R_XFER: if (go && at_last) nstate = R_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge rx_clk or negedge rx_rst_n) begin
        if (!rx_rst_n) begin
            sel     <= 1'b0;
            idx     <= '0;
            rd_bin  <= '0;
            rd_gray <= '0;
            rx_data <= '0;
            rx_soc  <= 1'b0;
            rx_prty <= 1'b1;
            rx_clav <= 1'b0;
        end else begin
            rx_clav <= addr_hit && avail;
            if (rx_enb_n) sel <= addr_hit;
            if (go) begin
                rx_data <= word;
                rx_soc  <= (state == R_IDLE);
                rx_prty <= ~^word;
                if (at_last) begin
                    idx     <= '0;
                    rd_bin  <= rd_bin + 1'b1;
                    rd_gray <= (rd_bin + 1'b1) ^ ((rd_bin + 1'b1) >> 1);
                end else begin
                    idx <= cur + 6'd1;
                end
            end else begin
                rx_data <= '0;
                rx_soc  <= 1'b0;
                rx_prty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port
    import utopia_rx_pkg::*;
#(
    parameter int CELLS = 4
) (
    input  logic        wr_clk,
    input  logic        wr_rst_n,
    input  logic        wr_valid,
    input  logic        wr_soc,
    input  logic [7:0]  wr_byte,
    output logic        ovf_flag,
    input  logic        rx_clk,
    input  logic        rx_rst_n,
    input  logic        cfg_wide,
    input  logic [4:0]  cfg_port_addr,
    input  logic        rx_enb_n,
    input  logic [4:0]  rx_addr,
    output logic [15:0] rx_data,
    output logic        rx_soc,
    output logic        rx_prty,
    output logic        rx_clav
);
    localparam int PW    = $clog2(CELLS) + 1;
    localparam int DEPTH = CELLS * CELL_WORDS;
    localparam int AW    = $clog2(DEPTH);

    logic [PW-1:0] wr_gray, wr_gray_rx;
    logic [PW-1:0] rd_gray, rd_gray_wr;
    logic [1:0]    mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [15:0]   mem_wdata, mem_rdata;

    utopia_rx_wr #(.CELLS(CELLS), .PW(PW), .AW(AW)) u_wr (
        .wr_clk       (wr_clk),
        .wr_rst_n     (wr_rst_n),
        .wr_valid     (wr_valid),
        .wr_soc       (wr_soc),
        .wr_byte      (wr_byte),
        .rd_gray_sync (rd_gray_wr),
        .wr_gray      (wr_gray),
        .mem_we       (mem_we),
        .mem_addr     (mem_waddr),
        .mem_wdata    (mem_wdata),
        .ovf_flag     (ovf_flag)
    );

    utopia_rx_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    utopia_rx_sync #(.W(PW)) u_sync_w2r (
        .clk   (rx_clk),
        .rst_n (rx_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_rx)
    );

    utopia_rx_sync #(.W(PW)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_wr)
    );

    utopia_rx_rd #(.CELLS(CELLS), .PW(PW), .AW(AW)) u_rd (
        .rx_clk        (rx_clk),
        .rx_rst_n      (rx_rst_n),
        .cfg_wide      (cfg_wide),
        .cfg_port_addr (cfg_port_addr),
        .rx_enb_n      (rx_enb_n),
        .rx_addr       (rx_addr),
        .wr_gray_sync  (wr_gray_rx),
        .rd_gray       (rd_gray),
        .mem_raddr     (mem_raddr),
        .mem_rdata     (mem_rdata),
        .rx_data       (rx_data),
        .rx_soc        (rx_soc),
        .rx_prty       (rx_prty),
        .rx_clav       (rx_clav)
    );
endmodule

// File: rtl/utopia_rx_chk.sv
module utopia_rx_chk (
    input logic        wr_clk,
    input logic        wr_rst_n,
    input logic        ovf_flag,
    input logic        rx_clk,
    input logic        rx_rst_n,
    input logic        cfg_wide,
    input logic [4:0]  cfg_port_addr,
    input logic        rx_enb_n,
    input logic [4:0]  rx_addr,
    input logic [15:0] rx_data,
    input logic        rx_soc,
    input logic        rx_prty,
    input logic        rx_clav
);
    p_parity_odd_r7: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (^{rx_prty, (cfg_wide ? rx_data : {8'h00, rx_data[7:0]})}) == 1'b1);

    p_narrow_upper_zero_r4: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        !cfg_wide |-> (rx_data[15:8] == 8'h00));

    p_quiet_when_disabled_r3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        rx_enb_n |=> ((rx_data == 16'h0000) && !rx_soc));

    p_clav_gated_r2: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        (rx_addr != cfg_port_addr) |=> !rx_clav);

    p_soc_single_r6: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        rx_soc |=> !rx_soc);

    p_ovf_sticky_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ovf_flag |=> ovf_flag);
endmodule

bind utopia_rx_port utopia_rx_chk i_chk (
    .wr_clk        (wr_clk),
    .wr_rst_n      (wr_rst_n),
    .ovf_flag      (ovf_flag),
    .rx_clk        (rx_clk),
    .rx_rst_n      (rx_rst_n),
    .cfg_wide      (cfg_wide),
    .cfg_port_addr (cfg_port_addr),
    .rx_enb_n      (rx_enb_n),
    .rx_addr       (rx_addr),
    .rx_data       (rx_data),
    .rx_soc        (rx_soc),
    .rx_prty       (rx_prty),
    .rx_clav       (rx_clav)
);

// File: tb/test_utopia_rx_port.sv
`timescale 1ns/1ps
module test_utopia_rx_port;
    localparam logic [4:0] MY_ADDR    = 5'd9;
    localparam logic [4:0] OTHER_ADDR = 5'd3;

    logic        wr_clk = 1'b0, rx_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_soc = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        ovf_flag;
    logic        cfg_wide = 1'b0;
    logic [4:0]  cfg_port_addr = MY_ADDR;
    logic        rx_enb_n = 1'b1;
    logic [4:0]  rx_addr = OTHER_ADDR;
    logic [15:0] rx_data;
    logic        rx_soc, rx_prty, rx_clav;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 rx_clk = ~rx_clk;   // 250 MHz
    always #3 wr_clk = ~wr_clk;

    utopia_rx_port i_utopia_rx_port (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cb(input int id, input int j);
        return 8'((id * 7 + j * 3 + 1) & 255);
    endfunction

    task automatic put(input logic soc, input logic [7:0] b);
        @(negedge wr_clk);
        wr_valid = 1'b1; wr_soc = soc; wr_byte = b;
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_valid = 1'b0; wr_soc = 1'b0;
    endtask

    task automatic write_bytes(input int id, input int n);
        for (int j = 0; j < n; j++) put(j == 0, cb(id, j));
        wr_idle();
    endtask

    task automatic settle();
        repeat (14) @(negedge rx_clk);
    endtask

    task automatic poll(input logic [4:0] a, output logic c);
        @(negedge rx_clk);
        rx_enb_n = 1'b1; rx_addr = a;
        @(negedge rx_clk);
        c = rx_clav;
    endtask

    // reads one cell; pause_at < 0 means no pause
    task automatic read_cell(input int id, input int pause_at, input string req);
        int t;
        logic [15:0] exp;
        t = cfg_wide ? 27 : 53;
        @(negedge rx_clk);
        rx_enb_n = 1'b1; rx_addr = MY_ADDR;
        @(negedge rx_clk);
        rx_enb_n = 1'b0;
        for (int i = 1; i <= t; i++) begin
            @(negedge rx_clk);
            if (cfg_wide) exp = {cb(id, 2*(i-1)), (i == 27) ? 8'h00 : cb(id, 2*(i-1)+1)};
            else          exp = {8'h00, cb(id, i-1)};
            check(rx_data == exp, {req, " data"}, int'(rx_data), int'(exp));
            check(rx_soc == (i == 1), "R6 soc", int'(rx_soc), int'(i == 1));
            check(rx_prty == ~^exp, "R7 parity", int'(rx_prty), int'(~^exp));
            if (i == t) rx_enb_n = 1'b1;
            else if (i == pause_at) begin
                rx_enb_n = 1'b1;
                repeat (2) begin
                    @(negedge rx_clk);
                    check(rx_data == 16'h0 && !rx_soc, "R11 pause quiet", int'(rx_data), 0);
                end
                rx_enb_n = 1'b0;
            end
        end
        @(negedge rx_clk);
    endtask

    task automatic t_reset();
        check(rx_clav == 1'b0, "R12 clav", int'(rx_clav), 0);
        check(rx_data == 16'h0, "R12 data", int'(rx_data), 0);
        check(rx_soc == 1'b0, "R12 soc", int'(rx_soc), 0);
        check(rx_prty == 1'b1, "R12 parity", int'(rx_prty), 1);
        check(ovf_flag == 1'b0, "R12 ovf", int'(ovf_flag), 0);
    endtask

    task automatic t_commit_narrow();
        logic c;
        for (int j = 0; j < 52; j++) put(j == 0, cb(1, j));
        wr_idle();
        settle();
        poll(MY_ADDR, c);
        check(c == 1'b0, "R1 clav before last byte", int'(c), 0);
        put(1'b0, cb(1, 52));
        wr_idle();
        settle();
        poll(MY_ADDR, c);
        check(c == 1'b1, "R2 clav after commit", int'(c), 1);
        read_cell(1, -1, "R4");
        settle();
        poll(MY_ADDR, c);
        check(c == 1'b0, "R2 clav after drain", int'(c), 0);
    endtask

    task automatic t_wide();
        cfg_wide = 1'b1;
        write_bytes(2, 53);
        settle();
        read_cell(2, -1, "R5");
        cfg_wide = 1'b0;
    endtask

    task automatic t_address();
        logic c;
        write_bytes(3, 53);
        settle();
        poll(OTHER_ADDR, c);
        check(c == 1'b0, "R2 clav other addr", int'(c), 0);
        @(negedge rx_clk);
        rx_enb_n = 1'b0;
        repeat (8) begin
            @(negedge rx_clk);
            check(rx_data == 16'h0 && !rx_soc, "R3 unselected quiet", int'(rx_data), 0);
        end
        rx_enb_n = 1'b1;
        poll(MY_ADDR, c);
        check(c == 1'b1, "R3 cell kept", int'(c), 1);
        read_cell(3, -1, "R3");
    endtask

    task automatic t_pause();
        write_bytes(4, 53);
        settle();
        read_cell(4, 20, "R11");
    endtask

    task automatic t_restart();
        logic c;
        write_bytes(5, 10);
        write_bytes(6, 53);
        settle();
        read_cell(6, -1, "R10");
        settle();
        poll(MY_ADDR, c);
        check(c == 1'b0, "R10 single cell", int'(c), 0);
    endtask

    task automatic t_order_overflow();
        logic c;
        for (int id = 7; id <= 10; id++) write_bytes(id, 53);
        @(negedge wr_clk);
        check(ovf_flag == 1'b0, "R9 no ovf yet", int'(ovf_flag), 0);
        write_bytes(11, 53);
        @(negedge wr_clk);
        check(ovf_flag == 1'b1, "R9 ovf set", int'(ovf_flag), 1);
        settle();
        for (int id = 7; id <= 10; id++) read_cell(id, -1, "R8");
        settle();
        poll(MY_ADDR, c);
        check(c == 1'b0, "R9 dropped cell absent", int'(c), 0);
        check(ovf_flag == 1'b1, "R9 ovf sticky", int'(ovf_flag), 1);
    endtask

    initial begin
        repeat (4) @(negedge rx_clk);
        wr_rst_n = 1'b1; rx_rst_n = 1'b1;
        repeat (3) @(negedge rx_clk);
        t_reset();
        t_commit_narrow();
        t_wide();
        t_address();
        t_pause();
        t_restart();
        t_order_overflow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule